// File: doc/BRIEF.md
# Unlock-Sequenced Flash Control Register

This block is an 8-bit control and status register placed between a processor bus and an embedded flash controller. Software uses it to enter a rewrite mode, to reset the flash controller, and to lift write protection from the array. It also reads back a ready flag that reflects engine activity. Each of the three control bits is guarded: it can only be set to 1 by a write of 0 to that bit followed directly by a write of 1, counting only writes to this register. A single write of 0 always clears the bit.

The flash engine supplies two status inputs: busy and erase-in-progress. If the controller reset bit is set while an erase is running, a down-counter holds the ready flag low for `RECOVER_CYCLES` clock cycles, which corresponds to 5 ms at the clock rate. The bus port is a plain single-cycle strobe. It has no valid/ready handshake because no data stream flows through the block. The read data is combinational from the register state.

Top module: `flashctl_guard_reg`

## Requirements
- R1: After reset, `rd_data` is 0x01 when the engine is idle, and `rewrite_mode`, `flash_ctl_rst` and `array_wr_en` are 0.
- R2: Bit 0 of `rd_data` reads 1 only when `eng_busy` is 0 and no recovery wait is running. Otherwise it reads 0.
- R3: Bit 1 (rewrite select, also driven on `rewrite_mode`) becomes 1 only when a write with bit 1 = 0 is followed by the next register write with bit 1 = 1. A write with bit 1 = 0 clears it.
- R4: A write of 1 to a guarded bit (bits 1, 3, 4) whose previous register write did not carry 0 in that bit leaves the bit unchanged.
- R5: Bit 2 of `rd_data` is a read-only copy of bit 1, delayed by one clock cycle.
- R6: Bit 3 (controller reset, driven on `flash_ctl_rst`) follows the 0-then-1 rule, and only while bit 1 is already 1. A write of 0 to bit 3 releases it.
- R7: Bit 4 (write enable) follows the 0-then-1 rule. `array_wr_en` is bit 4 AND bit 1.
- R8: A write that carries 0 in bit 1 forces bits 3 and 4 to 0, whatever values that write carries for them.
- R9: Bits 7:5 ignore writes and read 0.
- R10: When bit 3 goes from 0 to 1 while `eng_erasing` is 1, the ready flag reads 0 for exactly `RECOVER_CYCLES` cycles, starting one cycle after the bit rises. The same rise without an erase starts no wait.
- R11: A write strobe with `reg_sel` low changes no bit and no arm state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Address match for this register |
| wr_en | input | 1 | Write strobe, one write per cycle when `reg_sel` is high |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| eng_busy | input | 1 | Flash engine is programming or erasing |
| eng_erasing | input | 1 | Flash engine is erasing |
| rewrite_mode | output | 1 | Rewrite mode enable (bit 1) |
| flash_ctl_rst | output | 1 | Flash controller reset (bit 3) |
| array_wr_en | output | 1 | Array write enable (bit 4 AND bit 1) |

## Verification
A wrong arm flag shows up at the very next register write. Either a guarded bit sets when it should not, or it fails to set, and the change is visible on `rd_data` and on the output pins in the cycle after that write. A stale entry flag shows on bit 2 one cycle after the select bit changes. A mis-loaded or mis-counting recovery counter stretches or shortens the low period of bit 0, so the bench measures that low period to the exact cycle.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned B_READY  = 0;
  localparam int unsigned B_SEL    = 1;
  localparam int unsigned B_ENTRY  = 2;
  localparam int unsigned B_CRST   = 3;
  localparam int unsigned B_WREN   = 4;
  localparam int unsigned N_GUARD  = 3;

  // bit position of each guarded field, index 0..N_GUARD-1
  function automatic int unsigned guard_pos(input int unsigned idx);
    case (idx)
      0:       guard_pos = B_SEL;
      1:       guard_pos = B_CRST;
      default: guard_pos = B_WREN;
    endcase
  endfunction
endpackage

// File: rtl/fcg_seq_guard.sv
module fcg_seq_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic din,
  input  logic cond,
  input  logic force_clr,
  output logic val
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      val   <= 1'b0;
    end else begin
      if (wr) armed <= ~din;
      if (force_clr)                  val <= 1'b0;
      else if (wr && !din)            val <= 1'b0;
      else if (wr && armed && cond)   val <= 1'b1;
    end
  end

  // R3 R6 R7: a guarded bit rises only on an armed write of 1
  p_set_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(val) |-> $past(wr && din && armed && cond));
endmodule

// File: rtl/fcg_recover_timer.sv
module fcg_recover_timer #(
  parameter int unsigned RECOVER_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic crst_bit,
  input  logic erasing,
  output logic recovering
);
  localparam int unsigned CW = $clog2(RECOVER_CYCLES + 1);

  logic          crst_q;
  logic [CW-1:0] cnt;
  logic          load;

  assign load = crst_bit && !crst_q && erasing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crst_q <= 1'b0;
      cnt    <= '0;
    end else begin
      crst_q <= crst_bit;
      if (load)           cnt <= CW'(RECOVER_CYCLES);
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign recovering = (cnt != '0);

  p_recover_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/flashctl_guard_reg.sv
module flashctl_guard_reg #(
  parameter int unsigned RECOVER_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       eng_busy,
  input  logic       eng_erasing,
  output logic       rewrite_mode,
  output logic       flash_ctl_rst,
  output logic       array_wr_en
);
  import fcg_pkg::*;

  logic                wr;
  logic                sel_clear;
  logic [N_GUARD-1:0]  g_val;
  logic [N_GUARD-1:0]  g_cond;
  logic [N_GUARD-1:0]  g_clr;
  logic                sel_bit, crst_bit, wren_bit;
  logic                entry_q;
  logic                recovering;
  logic                ready;

  assign wr        = reg_sel && wr_en;
  assign sel_clear = wr && !wr_data[B_SEL];

  assign sel_bit  = g_val[0];
  assign crst_bit = g_val[1];
  assign wren_bit = g_val[2];

  always_comb begin
    for (int i = 0; i < N_GUARD; i++) begin
      g_cond[i] = (guard_pos(i) == B_CRST) ? sel_bit : 1'b1;
      g_clr[i]  = (guard_pos(i) == B_SEL)  ? 1'b0   : sel_clear;
    end
  end

  for (genvar gi = 0; gi < N_GUARD; gi++) begin : g_guard
    fcg_seq_guard u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr),
      .din       (wr_data[guard_pos(gi)]),
      .cond      (g_cond[gi]),
      .force_clr (g_clr[gi]),
      .val       (g_val[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) entry_q <= 1'b0;
    else        entry_q <= sel_bit;
  end

  fcg_recover_timer #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .crst_bit   (crst_bit),
    .erasing    (eng_erasing),
    .recovering (recovering)
  );

  assign ready         = !eng_busy && !recovering;
  assign rewrite_mode  = sel_bit;
  assign flash_ctl_rst = crst_bit;
  assign array_wr_en   = wren_bit && sel_bit;
  assign rd_data       = {3'b000, wren_bit, crst_bit, entry_q, sel_bit, ready};

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);
  p_entry_lags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rewrite_mode) |=> rd_data[B_ENTRY]);
  p_wren_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr_en |-> rewrite_mode);
  p_rst_needs_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_ctl_rst) |-> $past(rewrite_mode));
  p_force_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && wr_en && !wr_data[B_SEL]) |=> (!flash_ctl_rst && !array_wr_en));
  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !rd_data[B_READY]);
endmodule

// File: tb/tb_flashctl_guard_reg.sv
module tb_flashctl_guard_reg;
  localparam int unsigned NREC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       eng_busy = 1'b0;
  logic       eng_erasing = 1'b0;
  logic       rewrite_mode, flash_ctl_rst, array_wr_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  flashctl_guard_reg #(.RECOVER_CYCLES(NREC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .eng_busy(eng_busy),
    .eng_erasing(eng_erasing), .rewrite_mode(rewrite_mode),
    .flash_ctl_rst(flash_ctl_rst), .array_wr_en(array_wr_en)
  );

  // {write data, expected rd_data, expected {array_wr_en, flash_ctl_rst, rewrite_mode}}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {8'h02, 8'h01, 3'b000},  // R4 one without arm
    {8'h00, 8'h01, 3'b000},  // R3 arm
    {8'h02, 8'h07, 3'b001},  // R3 R5 set select, entry follows
    {8'h0A, 8'h0F, 3'b011},  // R6 reset set while select on
    {8'h1A, 8'h1F, 3'b111},  // R7 write enable, R4 bit3 unarmed holds
    {8'h12, 8'h17, 3'b101},  // R6 release
    {8'hF2, 8'h17, 3'b101},  // R9 R4 upper ignored
    {8'h10, 8'h01, 3'b000},  // R8 clearing select clears bits 3,4
    {8'h12, 8'h07, 3'b001},  // R3 select again, R4 bit4 unarmed
    {8'h08, 8'h01, 3'b000}   // R8 forced clear beats armed bit3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] d, input logic sel);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    reg_sel = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int lowcnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd", rd_data, 8'h01);
    check("R1 outs", {array_wr_en, flash_ctl_rst, rewrite_mode}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i][18:11], 1'b1);
      @(negedge clk);  // entry flag settles one cycle later
      check($sformatf("R3-table rd vec%0d", i), rd_data, VEC[i][10:3]);
      check($sformatf("R7-table outs vec%0d", i),
            {array_wr_en, flash_ctl_rst, rewrite_mode}, VEC[i][2:0]);
    end

    // R11: deselected write ignored, arm from last write survives
    bus_wr(8'h02, 1'b0);
    @(negedge clk);
    check("R11 ignored", rd_data, 8'h01);
    bus_wr(8'h02, 1'b1);
    @(negedge clk);
    check("R11 arm kept", rd_data, 8'h07);

    // R5: entry flag lags select by one cycle
    bus_wr(8'h00, 1'b1);
    check("R5 lag", rd_data[2:1], 2'b10);
    @(negedge clk);
    check("R5 settled", rd_data[2:1], 2'b00);
    bus_wr(8'h02, 1'b1);
    check("R5 lag rise", rd_data[2:1], 2'b01);
    @(negedge clk);

    // R2: busy pulls ready low
    eng_busy = 1'b1;
    @(negedge clk);
    check("R2 busy", rd_data[0], 1'b0);
    eng_busy = 1'b0;
    @(negedge clk);
    check("R2 idle", rd_data[0], 1'b1);

    // R10: reset during erase -> recovery wait
    bus_wr(8'h02, 1'b1);
    eng_erasing = 1'b1;
    bus_wr(8'h0A, 1'b1);
    check("R10 ready before load", rd_data[0], 1'b1);
    lowcnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (rd_data[0] == 1'b0) lowcnt++;
      else break;
    end
    check("R10 wait length", lowcnt, NREC);
    check("R6 reset out", flash_ctl_rst, 1'b1);
    eng_erasing = 1'b0;

    // R10: reset without erase -> no wait
    bus_wr(8'h02, 1'b1);
    check("R6 released", flash_ctl_rst, 1'b0);
    bus_wr(8'h0A, 1'b1);
    lowcnt = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (rd_data[0] == 1'b0) lowcnt++;
    end
    check("R10 no wait", lowcnt, 0);

    // R6: bit3 sequence with select off does nothing
    bus_wr(8'h00, 1'b1);
    bus_wr(8'h00, 1'b1);
    bus_wr(8'h08, 1'b1);
    @(negedge clk);
    check("R6 needs select", rd_data, 8'h01);

    summary();
  end
endmodule